// File: doc/BRIEF.md
# Latched Tri-Port Bus Exchanger

This block joins a processor-side data port to two memory-side data ports, so that one processor bus can feed an even and an odd memory bank. Data flows outward from the processor port to either memory port or to both at once. Data flows back to the processor port from whichever memory port the select input names. Each of the four directional paths has its own latch with its own enable. The latch is transparent while its enable is high and holds the last value it passed once the enable falls. This is how the block supports interleaved accesses and address multiplexing.

Every port has an active-low output enable of its own. Pins are modelled as split signals, because only this form is safe to synthesise. For each port, an external driver value and a driver-active flag come in, and the resolved pin level goes out. When neither the block nor the external driver is active, a per-port keeper holds the last resolved level. The latches are modelled in a single clock domain. A latch passes its input straight through while its enable is high. It keeps the value captured at the last clock edge where its enable was high. Latches and keepers are cleared by reset.

Top module: `bus_exchanger`

## Requirements
- R1: With the processor port receiving from its external driver, both outward latches open and both memory-port enables active, both memory pins show the processor-port value in the same cycle (broadcast).
- R2: A latch whose enable is high passes its input straight through to the pin it drives, with no clock delay.
- R3: After a latch enable goes low, the pin fed by that latch keeps the value the latch saw at the last clock edge where the enable was high, for as long as the enable stays low.
- R4: With the processor-port enable active (low), select high routes the 1B return latch to the processor pin and select low routes the 2B return latch.
- R5: A port whose active-low enable is high is not driven by the block, and its pin shows the external driver value whenever that driver is active.
- R6: A pin that neither the block nor an external driver drives keeps the level it had at the previous clock edge.
- R7: The two memory-port enables are independent: one memory port can drive its latched value while the other receives new data that reaches the processor port through its return latch.
- R8: Every latch takes its input from the receive value of its source port: the external driver value when that driver is active, otherwise the keeper level (the pin level at the previous clock edge).
- R9: Reset clears all four latches and all three keepers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for latch capture and keepers |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_1b | input | 1 | Return select: 1 = 1B path, 0 = 2B path |
| le_a1b | input | 1 | Enable of latch from processor port to 1B |
| le_a2b | input | 1 | Enable of latch from processor port to 2B |
| le_1ba | input | 1 | Enable of latch from 1B to processor port |
| le_2ba | input | 1 | Enable of latch from 2B to processor port |
| oe_a_n | input | 1 | Active-low drive enable, processor port |
| oe_1b_n | input | 1 | Active-low drive enable, 1B port |
| oe_2b_n | input | 1 | Active-low drive enable, 2B port |
| a_ext | input | 12 | External driver value on processor port |
| a_ext_en | input | 1 | External driver active on processor port |
| b1_ext | input | 12 | External driver value on 1B port |
| b1_ext_en | input | 1 | External driver active on 1B port |
| b2_ext | input | 12 | External driver value on 2B port |
| b2_ext_en | input | 1 | External driver active on 2B port |
| a_pin | output | 12 | Resolved processor-port pin level |
| b1_pin | output | 12 | Resolved 1B pin level |
| b2_pin | output | 12 | Resolved 2B pin level |

## Verification
The assertions assume that an external driver is never active on a port while the block drives that port. Contention is treated as outside the contract rather than resolved. The stimulus keeps to this rule by raising a port's external-driver flag only while that port's enable is deasserted. Within that constraint, select, the latch enables, the drive enables and the data vary freely, both in directed cases and in a long pseudo-random sweep. Every pin is compared with a bench model every cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    typedef enum logic {
        RET_FROM_2B = 1'b0,
        RET_FROM_1B = 1'b1
    } ret_sel_e;
    localparam int unsigned NUM_B = 2;
endpackage

// File: rtl/xchg_latch.sv
module xchg_latch #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] hold;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le) st_d.hold = d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = le ? d : st_q.hold;

    // R3: a closed latch keeps its output steady
    p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le && $past(!le)) |-> $stable(q));
endmodule

// File: rtl/xchg_pad.sv
module xchg_pad #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv_en,
    input  logic [W-1:0] core,
    input  logic         ext_en,
    input  logic [W-1:0] ext,
    output logic [W-1:0] pin,
    output logic [W-1:0] recv
);
    typedef struct packed {
        logic [W-1:0] keep;
    } pad_st_t;

    pad_st_t st_d, st_q;

    always_comb begin
        recv = ext_en ? ext : st_q.keep;
        pin  = drv_en ? core : recv;
        st_d = st_q;
        st_d.keep = pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: undriven pin holds the previous level
    p_keeper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !drv_en && !ext_en) |-> pin == $past(pin));
    // R5: external driver visible on an undriven port
    p_ext_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en && ext_en) |-> pin == ext);
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_1b,
    input  logic         le_a1b,
    input  logic         le_a2b,
    input  logic         le_1ba,
    input  logic         le_2ba,
    input  logic         oe_a_n,
    input  logic         oe_1b_n,
    input  logic         oe_2b_n,
    input  logic [W-1:0] a_ext,
    input  logic         a_ext_en,
    input  logic [W-1:0] b1_ext,
    input  logic         b1_ext_en,
    input  logic [W-1:0] b2_ext,
    input  logic         b2_ext_en,
    output logic [W-1:0] a_pin,
    output logic [W-1:0] b1_pin,
    output logic [W-1:0] b2_pin
);
    import xchg_pkg::*;

    localparam int unsigned NB = NUM_B;

    logic [NB-1:0]        le_out, le_ret, oe_b_n, b_ext_en;
    logic [NB-1:0][W-1:0] b_ext, b_pin, b_recv, out_q, ret_q;
    logic [W-1:0]         a_recv, a_core;
    ret_sel_e             rsel;

    assign le_out   = {le_a2b, le_a1b};
    assign le_ret   = {le_2ba, le_1ba};
    assign oe_b_n   = {oe_2b_n, oe_1b_n};
    assign b_ext_en = {b2_ext_en, b1_ext_en};
    assign b_ext    = {b2_ext, b1_ext};
    assign rsel     = ret_sel_e'(sel_1b);

    always_comb begin
        a_core = (rsel == RET_FROM_1B) ? ret_q[0] : ret_q[1];
    end

    xchg_pad #(.W(W)) u_pad_a (
        .clk(clk), .rst_n(rst_n), .drv_en(!oe_a_n), .core(a_core),
        .ext_en(a_ext_en), .ext(a_ext), .pin(a_pin), .recv(a_recv)
    );

    for (genvar gi = 0; gi < NB; gi++) begin : g_bside
        xchg_latch #(.W(W)) u_lat_out (
            .clk(clk), .rst_n(rst_n), .le(le_out[gi]), .d(a_recv), .q(out_q[gi])
        );
        xchg_latch #(.W(W)) u_lat_ret (
            .clk(clk), .rst_n(rst_n), .le(le_ret[gi]), .d(b_recv[gi]), .q(ret_q[gi])
        );
        xchg_pad #(.W(W)) u_pad_b (
            .clk(clk), .rst_n(rst_n), .drv_en(!oe_b_n[gi]), .core(out_q[gi]),
            .ext_en(b_ext_en[gi]), .ext(b_ext[gi]), .pin(b_pin[gi]), .recv(b_recv[gi])
        );
    end

    assign b1_pin = b_pin[0];
    assign b2_pin = b_pin[1];

    // R1: broadcast of processor data to both memory ports
    p_broadcast_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && a_ext_en && le_a1b && le_a2b && !oe_1b_n && !oe_2b_n)
        |-> (b1_pin == a_ext && b2_pin == a_ext));
    // R4: select high returns 1B data straight through an open latch
    p_sel_1b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && sel_1b && le_1ba && oe_1b_n && b1_ext_en) |-> a_pin == b1_ext);
    // R7: 2B receives and returns while 1B is free to drive
    p_sel_2b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !sel_1b && le_2ba && oe_2b_n && b2_ext_en) |-> a_pin == b2_ext);
endmodule

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_1b = 0, le_a1b = 0, le_a2b = 0, le_1ba = 0, le_2ba = 0;
    logic oe_a_n = 1, oe_1b_n = 1, oe_2b_n = 1;
    logic [W-1:0] a_ext = '0, b1_ext = '0, b2_ext = '0;
    logic a_ext_en = 0, b1_ext_en = 0, b2_ext_en = 0;
    logic [W-1:0] a_pin, b1_pin, b2_pin;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] mh_a1b = '0, mh_a2b = '0, mh_1ba = '0, mh_2ba = '0;
    logic [W-1:0] mk_a = '0, mk_b1 = '0, mk_b2 = '0;
    logic [W-1:0] ex_a, ex_b1, ex_b2, rv_a, rv_b1, rv_b2;

    always #5 clk = ~clk;

    bus_exchanger #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_1b(sel_1b),
        .le_a1b(le_a1b), .le_a2b(le_a2b), .le_1ba(le_1ba), .le_2ba(le_2ba),
        .oe_a_n(oe_a_n), .oe_1b_n(oe_1b_n), .oe_2b_n(oe_2b_n),
        .a_ext(a_ext), .a_ext_en(a_ext_en), .b1_ext(b1_ext), .b1_ext_en(b1_ext_en),
        .b2_ext(b2_ext), .b2_ext_en(b2_ext_en),
        .a_pin(a_pin), .b1_pin(b1_pin), .b2_pin(b2_pin)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        logic [W-1:0] o1, o2, r1, r2;
        rv_a  = a_ext_en  ? a_ext  : mk_a;
        rv_b1 = b1_ext_en ? b1_ext : mk_b1;
        rv_b2 = b2_ext_en ? b2_ext : mk_b2;
        o1 = le_a1b ? rv_a : mh_a1b;
        o2 = le_a2b ? rv_a : mh_a2b;
        r1 = le_1ba ? rv_b1 : mh_1ba;
        r2 = le_2ba ? rv_b2 : mh_2ba;
        ex_a  = !oe_a_n  ? (sel_1b ? r1 : r2) : rv_a;
        ex_b1 = !oe_1b_n ? o1 : rv_b1;
        ex_b2 = !oe_2b_n ? o2 : rv_b2;
    endtask

    task automatic model_clock();
        if (!rst_n) begin
            mh_a1b = '0; mh_a2b = '0; mh_1ba = '0; mh_2ba = '0;
            mk_a = '0; mk_b1 = '0; mk_b2 = '0;
        end else begin
            if (le_a1b) mh_a1b = rv_a;
            if (le_a2b) mh_a2b = rv_a;
            if (le_1ba) mh_1ba = rv_b1;
            if (le_2ba) mh_2ba = rv_b2;
            mk_a = ex_a; mk_b1 = ex_b1; mk_b2 = ex_b2;
        end
    endtask

    // compare all pins against the model, tag by the rule in force
    task automatic settle_and_compare();
        #2;
        model_eval();
        check(!oe_a_n ? "R4" : (a_ext_en ? "R5" : "R6"), a_pin, ex_a);
        check(!oe_1b_n ? (le_a1b ? "R2" : "R3") : (b1_ext_en ? "R5" : "R6"), b1_pin, ex_b1);
        check(!oe_2b_n ? (le_a2b ? "R2" : "R3") : (b2_ext_en ? "R5" : "R6"), b2_pin, ex_b2);
        model_clock();
    endtask

    task automatic idle();
        sel_1b = 0; le_a1b = 0; le_a2b = 0; le_1ba = 0; le_2ba = 0;
        oe_a_n = 1; oe_1b_n = 1; oe_2b_n = 1;
        a_ext_en = 0; b1_ext_en = 0; b2_ext_en = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset with open latches fed by nonzero data, then clear
        @(negedge clk);
        le_a1b = 1; le_1ba = 1; a_ext_en = 1; a_ext = 12'hFFF;
        @(negedge clk); idle(); @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R9", a_pin, '0); check("R9", b1_pin, '0); check("R9", b2_pin, '0);
        model_clock();
        @(negedge clk); oe_1b_n = 0; #2; check("R9", b1_pin, '0); model_clock();

        // R1 broadcast
        @(negedge clk); idle();
        a_ext_en = 1; a_ext = 12'hA5C; le_a1b = 1; le_a2b = 1; oe_1b_n = 0; oe_2b_n = 0;
        #2; check("R1", b1_pin, 12'hA5C); check("R1", b2_pin, 12'hA5C);
        #0; model_eval(); model_clock();
        // R3: close 1B latch, 2B stays open
        @(negedge clk); le_a1b = 0; a_ext = 12'h123;
        #2; check("R3", b1_pin, 12'hA5C); check("R2", b2_pin, 12'h123);
        model_eval(); model_clock();
        @(negedge clk); a_ext = 12'h456;
        #2; check("R3", b1_pin, 12'hA5C); check("R2", b2_pin, 12'h456);
        model_eval(); model_clock();

        // R4 select both ways
        @(negedge clk); idle();
        b1_ext_en = 1; b1_ext = 12'h3C3; b2_ext_en = 1; b2_ext = 12'h5A5;
        le_1ba = 1; le_2ba = 1; oe_a_n = 0; sel_1b = 1;
        #2; check("R4", a_pin, 12'h3C3); model_eval(); model_clock();
        @(negedge clk); sel_1b = 0;
        #2; check("R4", a_pin, 12'h5A5); model_eval(); model_clock();

        // R5 / R6 keeper on 1B
        @(negedge clk); idle(); b1_ext_en = 1; b1_ext = 12'h777;
        #2; check("R5", b1_pin, 12'h777); model_eval(); model_clock();
        @(negedge clk); b1_ext_en = 0;
        #2; check("R6", b1_pin, 12'h777); model_eval(); model_clock();
        @(negedge clk);
        #2; check("R6", b1_pin, 12'h777); model_eval(); model_clock();

        // R7: 1B drives held value (A5C) while 2B receives and returns
        @(negedge clk); idle();
        oe_1b_n = 0; b2_ext_en = 1; b2_ext = 12'h0F0; le_2ba = 1; oe_a_n = 0;
        #2; check("R7", a_pin, 12'h0F0); check("R7", b1_pin, 12'hA5C);
        model_eval(); model_clock();

        // R8: A driven from 1B, then A keeper feeds the outward latch
        @(negedge clk); idle();
        oe_a_n = 0; sel_1b = 1; le_1ba = 1; b1_ext_en = 1; b1_ext = 12'h9E1;
        #2; check("R4", a_pin, 12'h9E1); model_eval(); model_clock();
        @(negedge clk); idle(); le_a1b = 1; oe_1b_n = 0;
        #2; check("R8", b1_pin, 12'h9E1); check("R6", a_pin, 12'h9E1);
        model_eval(); model_clock();

        // pseudo-random sweep under the no-contention rule
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            begin
                logic [31:0] r;
                r = $urandom;
                sel_1b = r[0]; le_a1b = r[1]; le_a2b = r[2]; le_1ba = r[3]; le_2ba = r[4];
                oe_a_n = r[5]; oe_1b_n = r[6]; oe_2b_n = r[7];
                a_ext_en  = oe_a_n  & r[8];
                b1_ext_en = oe_1b_n & r[9];
                b2_ext_en = oe_2b_n & r[10];
                a_ext  = W'($urandom);
                b1_ext = W'($urandom);
                b2_ext = W'($urandom);
            end
            settle_and_compare();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule